// File: doc/BRIEF.md
# Configurable Output Macrocell

This block models a single output cell of a programmable logic device. Sum-of-product terms from an AND/OR array come in, and the cell drives one I/O pin. It also returns two feedback lines to the array. Static configuration inputs choose the following:

- D or J-K operation of the storage element.
- Whether the pin shows the register or a combinational array term.
- The polarity of the register feedback.
- Which of eleven clock sources advances the register.

A bypassed register is not lost. It keeps running as a buried register, with its own input terms and its own feedback line. The combinational pin path and its feedback run alongside it, independently.

The eleven clock sources are modelled as per-source enables qualified on one system clock. Preload forces the register to a given value for test. A diagnostic observation input puts the register contents on the pin whatever the bypass setting is. The pin is represented as a data value plus an enable flag, and a low enable stands for high impedance.

Top module: `omc_macrocell`

## Requirements
- R1: A synchronous active-high `rst` clears the register to 0 at the next clock edge, taking priority over preload and normal updates.
- R2: With `cfg_jk`=0 (D mode), on an edge where the selected clock source is enabled and preload is inactive, the register takes the value of `d_term`.
- R3: With `cfg_jk`=1 (J-K mode, J=`d_term`, K=`k_term`) on an enabled edge: J=0 K=0 holds, J=1 K=0 sets, J=0 K=1 clears, and J=1 K=1 inverts the register.
- R4: `cfg_clk_sel` value n (0 to 10) selects `clk_src_en[n]` as the update qualifier. A value of 11 or more never updates the register, and an unselected enabled source has no effect.
- R5: With `cfg_bypass`=1, `pin_out` follows `comb_term` combinationally in the same cycle. With `cfg_bypass`=0, `pin_out` shows the register.
- R6: While bypassed, the register keeps updating from `d_term`/`k_term`, and its state is visible on `reg_fb`.
- R7: `reg_fb` equals the register value when `cfg_fb_inv`=0 and its complement when `cfg_fb_inv`=1.
- R8: `comb_fb` always equals the `pin_out` data value, including while `pin_oe` is low.
- R9: `pin_oe` follows `oe_term` when diagnostic observation is off.
- R10: When `preload_en`=1 at an edge (and `rst`=0), the register loads `preload_val`. This happens whether or not the clock source is enabled, and it overrides any D or J-K update on that edge.
- R11: With `diag_obs`=1, `pin_out` shows the register and `pin_oe` is 1, whatever `cfg_bypass`, `comb_term` and `oe_term` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_jk | input | 1 | 0 = D operation, 1 = J-K operation |
| cfg_bypass | input | 1 | 1 = pin driven by combinational term |
| cfg_fb_inv | input | 1 | 1 = inverted register feedback |
| cfg_clk_sel | input | 4 | Clock source select (0 to 10 valid) |
| clk_src_en | input | 11 | Per-source clock qualifiers |
| d_term | input | 1 | Register D input, or J in J-K mode |
| k_term | input | 1 | Register K input (J-K mode) |
| comb_term | input | 1 | Combinational pin path term |
| oe_term | input | 1 | Output enable term |
| preload_en | input | 1 | Force register to `preload_val` |
| preload_val | input | 1 | Preload value |
| diag_obs | input | 1 | Diagnostic observation of register on pin |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin drive enable (0 = high impedance) |
| comb_fb | output | 1 | Pin path feedback to array |
| reg_fb | output | 1 | Buried register feedback to array |

## Verification
Preload and a normal register update can land on the same edge. The bench provokes this by raising `preload_en` with the selected source enabled and with opposite D data, and then again with J=K=1 in J-K mode. It expects `preload_val` on the pin rather than the D value or the toggled value. A second coincidence is reset together with preload, where the bench expects 0. Bypass is also combined with a live buried-register update in the same cycle. There the bench judges `pin_out` against `comb_term` and `reg_fb` against the D input.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic {
        MODE_D  = 1'b0,
        MODE_JK = 1'b1
    } reg_mode_e;

    typedef struct packed {
        logic q;
    } omc_state_t;

endpackage

// File: rtl/omc_clk_select.sv
module omc_clk_select #(
    parameter int NUM_CLK = 11,
    localparam int SEL_W  = $clog2(NUM_CLK)
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_CLK-1:0] src_en,
    output logic               tick
);
    logic [NUM_CLK-1:0] hit;

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_src
        assign hit[g] = src_en[g] && (sel == SEL_W'(g));
    end

    assign tick = |hit;
endmodule

// File: rtl/omc_reg_core.sv
module omc_reg_core
    import omc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_mode_e mode,
    input  logic      tick,
    input  logic      j_d,
    input  logic      k_in,
    input  logic      preload_en,
    input  logic      preload_val,
    output logic      q
);
    omc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.q = 1'b0;
        end else if (preload_en) begin
            st_d.q = preload_val;
        end else if (tick) begin
            if (mode == MODE_D) begin
                st_d.q = j_d;
            end else begin
                case ({j_d, k_in})
                    2'b00:   st_d.q = st_q.q;
                    2'b10:   st_d.q = 1'b1;
                    2'b01:   st_d.q = 1'b0;
                    default: st_d.q = ~st_q.q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.q;

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !st_q.q);

    a_r10_preload_wins: assert property (@(posedge clk) disable iff (rst)
        preload_en |=> st_q.q == $past(preload_val));

    a_r3_jk_toggle: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_JK && j_d && k_in && !preload_en) |=> st_q.q != $past(st_q.q));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !preload_en) |=> $stable(st_q.q));
endmodule

// File: rtl/omc_pin_path.sv
module omc_pin_path (
    input  logic q,
    input  logic bypass,
    input  logic fb_inv,
    input  logic diag_obs,
    input  logic comb_term,
    input  logic oe_term,
    output logic pin_out,
    output logic pin_oe,
    output logic comb_fb,
    output logic reg_fb
);
    always_comb begin
        if (diag_obs) begin
            pin_out = q;
            pin_oe  = 1'b1;
        end else begin
            pin_out = bypass ? comb_term : q;
            pin_oe  = oe_term;
        end
        comb_fb = pin_out;
        reg_fb  = q ^ fb_inv;
    end
endmodule

// File: rtl/omc_macrocell.sv
module omc_macrocell
    import omc_pkg::*;
#(
    parameter int NUM_CLK = 11,
    localparam int SEL_W  = $clog2(NUM_CLK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_jk,
    input  logic               cfg_bypass,
    input  logic               cfg_fb_inv,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic [NUM_CLK-1:0] clk_src_en,
    input  logic               d_term,
    input  logic               k_term,
    input  logic               comb_term,
    input  logic               oe_term,
    input  logic               preload_en,
    input  logic               preload_val,
    input  logic               diag_obs,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               comb_fb,
    output logic               reg_fb
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_CLK - 1);

    logic      tick;
    logic      q;
    reg_mode_e mode;

    assign mode = reg_mode_e'(cfg_jk);

    omc_clk_select #(.NUM_CLK(NUM_CLK)) u_clk (
        .sel    (cfg_clk_sel),
        .src_en (clk_src_en),
        .tick   (tick)
    );

    omc_reg_core u_reg (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .tick        (tick),
        .j_d         (d_term),
        .k_in        (k_term),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .q           (q)
    );

    omc_pin_path u_pin (
        .q         (q),
        .bypass    (cfg_bypass),
        .fb_inv    (cfg_fb_inv),
        .diag_obs  (diag_obs),
        .comb_term (comb_term),
        .oe_term   (oe_term),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .comb_fb   (comb_fb),
        .reg_fb    (reg_fb)
    );

    a_r4_bad_sel_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg_clk_sel > LAST_SEL && !preload_en)
        |=> (reg_fb ^ cfg_fb_inv) == $past(reg_fb ^ cfg_fb_inv));

    a_r5_reg_on_pin: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && !diag_obs) |-> pin_out == (reg_fb ^ cfg_fb_inv));

    a_r11_diag_drives: assert property (@(posedge clk) disable iff (rst)
        diag_obs |-> (pin_oe && pin_out == (reg_fb ^ cfg_fb_inv)));
endmodule

// File: tb/tb_omc_macrocell.sv
`timescale 1ns/1ps
module tb_omc_macrocell;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_jk = 0, cfg_bypass = 0, cfg_fb_inv = 0;
    logic [3:0]  cfg_clk_sel = '0;
    logic [10:0] clk_src_en = '0;
    logic        d_term = 0, k_term = 0, comb_term = 0, oe_term = 0;
    logic        preload_en = 0, preload_val = 0, diag_obs = 0;
    logic        pin_out, pin_oe, comb_fb, reg_fb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    omc_macrocell dut (
        .clk(clk), .rst(rst), .cfg_jk(cfg_jk), .cfg_bypass(cfg_bypass),
        .cfg_fb_inv(cfg_fb_inv), .cfg_clk_sel(cfg_clk_sel), .clk_src_en(clk_src_en),
        .d_term(d_term), .k_term(k_term), .comb_term(comb_term), .oe_term(oe_term),
        .preload_en(preload_en), .preload_val(preload_val), .diag_obs(diag_obs),
        .pin_out(pin_out), .pin_oe(pin_oe), .comb_fb(comb_fb), .reg_fb(reg_fb)
    );

    // {jk, j/d, k, tick, expected q}
    localparam logic [4:0] VEC [12] = '{
        5'b0_1_0_1_1, 5'b0_0_0_0_1, 5'b0_0_0_1_0, 5'b1_1_0_1_1,
        5'b1_0_0_1_1, 5'b1_1_1_1_0, 5'b1_1_1_1_1, 5'b1_0_1_1_0,
        5'b1_1_1_0_0, 5'b1_1_1_1_1, 5'b0_1_0_1_1, 5'b0_0_0_1_0
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check("R1 reset pin", pin_out, 1'b0);
        check("R1 reset fb", reg_fb, 1'b0);
        check("R9 oe low", pin_oe, 1'b0);
        oe_term = 1'b1;
        #1 check("R9 oe high", pin_oe, 1'b1);

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_jk = VEC[i][4]; d_term = VEC[i][3]; k_term = VEC[i][2];
            clk_src_en = {10'b0, VEC[i][1]};
            edge_wait();
            check(VEC[i][4] ? "R3 jk vector" : "R2 d vector", pin_out, VEC[i][0]);
        end

        // R4 clock source selection, q currently 0
        @(negedge clk) cfg_jk = 0; d_term = 1; cfg_clk_sel = 4'd5; clk_src_en = ~(11'b1 << 5);
        edge_wait(); check("R4 other sources", pin_out, 1'b0);
        @(negedge clk) clk_src_en = 11'b1 << 5;
        edge_wait(); check("R4 selected source", pin_out, 1'b1);
        @(negedge clk) cfg_clk_sel = 4'd11; clk_src_en = '1; d_term = 0;
        edge_wait(); check("R4 sel 11", pin_out, 1'b1);
        @(negedge clk) cfg_clk_sel = 4'd15;
        edge_wait(); check("R4 sel 15", pin_out, 1'b1);
        @(negedge clk) cfg_clk_sel = 4'd10; clk_src_en = 11'b1 << 10; d_term = 0;
        edge_wait(); check("R4 sel 10", pin_out, 1'b0);
        @(negedge clk) d_term = 1; cfg_clk_sel = 4'd0; clk_src_en = 11'b1;
        edge_wait(); check("R2 reload", pin_out, 1'b1);

        // R7 feedback polarity, q=1
        @(negedge clk) cfg_fb_inv = 1; #1 check("R7 inverted", reg_fb, 1'b0);
        cfg_fb_inv = 0; #1 check("R7 true", reg_fb, 1'b1);

        // R5 / R6 bypass with buried register live
        @(negedge clk) cfg_bypass = 1; comb_term = 0;
        #1 check("R5 bypass 0", pin_out, 1'b0);
        check("R8 comb fb 0", comb_fb, 1'b0);
        comb_term = 1; #1 check("R5 bypass 1", pin_out, 1'b1);
        @(negedge clk) d_term = 0;
        edge_wait();
        check("R6 buried updates", reg_fb, 1'b0);
        check("R5 pin keeps comb", pin_out, 1'b1);
        @(negedge clk) d_term = 1; comb_term = 0;
        edge_wait();
        check("R6 buried sets", reg_fb, 1'b1);
        check("R5 pin follows comb", pin_out, 1'b0);

        // R8 feedback with output disabled
        @(negedge clk) oe_term = 0; comb_term = 1;
        #1 check("R8 oe off", pin_oe, 1'b0);
        check("R8 comb fb tristate", comb_fb, 1'b1);

        // R11 diagnostic observation, q=1, comb=0
        comb_term = 0; diag_obs = 1;
        #1 check("R11 diag data", pin_out, 1'b1);
        check("R11 diag oe", pin_oe, 1'b1);
        @(negedge clk) diag_obs = 0; cfg_bypass = 0; oe_term = 1;

        // R10 preload collisions, q=1
        @(negedge clk) d_term = 1; clk_src_en = 11'b1; preload_en = 1; preload_val = 0;
        edge_wait(); check("R10 preload beats D", pin_out, 1'b0);
        @(negedge clk) clk_src_en = '0; preload_val = 1;
        edge_wait(); check("R10 preload no tick", pin_out, 1'b1);
        @(negedge clk) cfg_jk = 1; d_term = 1; k_term = 1; clk_src_en = 11'b1; preload_val = 1;
        edge_wait(); check("R10 preload beats toggle", pin_out, 1'b1);
        @(negedge clk) rst = 1;
        edge_wait(); check("R1 reset beats preload", pin_out, 1'b0);
        @(negedge clk) rst = 0; preload_en = 0;
        edge_wait(); check("R3 toggle after reset", pin_out, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule